// File: doc/BRIEF.md
# Processor Reset Sequencer

This block turns the raw, active-low reset pin of a small 8-bit processor into the reset controls that the rest of the core and the board need. The pin is first passed through a two-flop synchronizer. A low-time counter then checks that the synchronized level has stayed low for a minimum number of consecutive clocks. Only after that is a reset accepted, so a short glitch on the pin has no effect.

While a reset is accepted, the block drives an active-high reset for peripherals. It also asserts clear strobes for the program counter and the instruction register, and clears the enables of every maskable interrupt. The enable of the non-maskable interrupt is never touched. In the same window it disables the serial output latch and asks for the address, data and control buses to float. A single-cycle pulse marks the first cycle of each accepted reset.

The reset is released synchronously, on the first clock edge after the synchronized pin reads high again. The state of the block is defined once the pin has been held low long enough to be accepted, which is what a power-up reset does.

Top module: `cpu_reset_seq`

## Requirements
- R1: While the reset pin (`rst_pin_n`, active low) stays high, every output stays low.
- R2: A low level on the pin that is sampled at MIN_LOW (default 3) or more consecutive rising edges is accepted. `periph_rst_o` goes high SYNC_STAGES+MIN_LOW-1 edges (default 4) after the first edge that samples the pin low.
- R3: A low level sampled at fewer than MIN_LOW consecutive edges is ignored, and every output stays low.
- R4: Once accepted, `periph_rst_o` stays high for as long as the pin is sampled low. It falls SYNC_STAGES edges (default 2) after the first edge that samples the pin high.
- R5: `pc_clr_o` and `ir_clr_o` are high in exactly the cycles where `periph_rst_o` is high.
- R6: `core_rst_pulse_o` is high for exactly one cycle per accepted reset, the first cycle in which `periph_rst_o` is high.
- R7: Bit i of `irq_en_clr_o` is the clear for interrupt i, with index 0 the non-maskable one (NMI_IDX=0) and higher indices lower priority. During reset every bit except bit 0 is high (default vector 5'b11110). Bit 0 is never high, and the whole vector is zero outside reset.
- R8: `sod_dis_o` and `bus_float_o` are high in exactly the cycles where `periph_rst_o` is high.
- R9: The low-time counter clears whenever the synchronized pin reads high. Two short low pulses separated by one high cycle do not add up to an accepted reset.
- R10: The low-time counter saturates at MIN_LOW. A reset held for many cycles keeps every reset output high throughout and gives only one core pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_pin_n | input | 1 | Raw external reset, active low, asynchronous to clk |
| periph_rst_o | output | 1 | Active-high reset for peripherals |
| core_rst_pulse_o | output | 1 | One-cycle pulse in the first cycle of an accepted reset |
| pc_clr_o | output | 1 | Program counter clear strobe |
| ir_clr_o | output | 1 | Instruction register clear strobe |
| irq_en_clr_o | output | NUM_IRQ | Per-interrupt enable clear; bit NMI_IDX is held low |
| sod_dis_o | output | 1 | Serial data output disable |
| bus_float_o | output | 1 | Request to tri-state the address, data and control buses |

## Verification
The bench targets a low pulse of exactly MIN_LOW sampled edges, which must produce a one-cycle reset, and one edge shorter, which must produce nothing. An off-by-one in the threshold shows up as the wrong one of these two firing. It also sends two short pulses split by a single high cycle: a counter that fails to clear would add them up and raise a false reset. A long hold tests saturation, where a counter that wraps would drop the reset or fire the core pulse again. The release timing is counted edge by edge to catch an extra or missing register stage, and the non-maskable bit of the enable-clear vector is watched through every reset.

// File: rtl/cpu_rstseq_pkg.sv
package cpu_rstseq_pkg;

  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_MIN_LOW     = 3;
  localparam int unsigned DEF_NUM_IRQ     = 5;
  localparam int unsigned DEF_NMI_IDX     = 0;

  // Width needed to hold a count from 0 up to lim inclusive.
  function automatic int unsigned cnt_width(input int unsigned lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction

  // Saturating increment used by the low-time counter.
  function automatic int unsigned sat_inc(input int unsigned cur, input int unsigned lim);
    return (cur >= lim) ? lim : cur + 1;
  endfunction

endpackage

// File: rtl/cpu_rstseq_sync.sv
module cpu_rstseq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) chain_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk) chain_q[g] <= chain_q[g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/cpu_rstseq_qual.sv
module cpu_rstseq_qual
  import cpu_rstseq_pkg::*;
#(
  parameter int unsigned MIN_LOW = DEF_MIN_LOW,
  localparam int unsigned CW     = cnt_width(MIN_LOW)
) (
  input  logic          clk,
  input  logic          sync_low_i,
  output logic [CW-1:0] low_cnt_o,
  output logic          qualified_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_next;
  logic          qual_q;

  always_comb begin
    if (sync_low_i) cnt_next = CW'(sat_inc(32'(cnt_q), MIN_LOW));
    else            cnt_next = '0;
  end

  always_ff @(posedge clk) begin
    cnt_q  <= cnt_next;
    qual_q <= sync_low_i && (cnt_next == CW'(MIN_LOW));
  end

  assign low_cnt_o   = cnt_q;
  assign qualified_o = qual_q;

endmodule

// File: rtl/cpu_rstseq_ctrl.sv
module cpu_rstseq_ctrl #(
  parameter int unsigned NUM_IRQ = 5,
  parameter int unsigned NMI_IDX = 0
) (
  input  logic               clk,
  input  logic               active_i,
  output logic               periph_rst_o,
  output logic               core_pulse_o,
  output logic               pc_clr_o,
  output logic               ir_clr_o,
  output logic [NUM_IRQ-1:0] irq_en_clr_o,
  output logic               sod_dis_o,
  output logic               bus_float_o
);

  logic active_d;

  always_ff @(posedge clk) active_d <= active_i;

  assign periph_rst_o = active_i;
  assign core_pulse_o = active_i && !active_d;
  assign pc_clr_o     = active_i;
  assign ir_clr_o     = active_i;
  assign sod_dis_o    = active_i;
  assign bus_float_o  = active_i;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
    if (g == NMI_IDX) begin : g_nmi
      assign irq_en_clr_o[g] = 1'b0;
    end else begin : g_mask
      assign irq_en_clr_o[g] = active_i;
    end
  end

endmodule

// File: rtl/cpu_reset_seq.sv
module cpu_reset_seq
  import cpu_rstseq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int unsigned MIN_LOW     = DEF_MIN_LOW,
  parameter int unsigned NUM_IRQ     = DEF_NUM_IRQ,
  parameter int unsigned NMI_IDX     = DEF_NMI_IDX
) (
  input  logic               clk,
  input  logic               rst_pin_n,
  output logic               periph_rst_o,
  output logic               core_rst_pulse_o,
  output logic               pc_clr_o,
  output logic               ir_clr_o,
  output logic [NUM_IRQ-1:0] irq_en_clr_o,
  output logic               sod_dis_o,
  output logic               bus_float_o
);

  localparam int unsigned CW = cnt_width(MIN_LOW);

  logic          sync_high;
  logic          sync_low;
  logic [CW-1:0] low_cnt;
  logic          qualified;

  cpu_rstseq_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .d_i (rst_pin_n),
    .q_o (sync_high)
  );

  assign sync_low = !sync_high;

  cpu_rstseq_qual #(.MIN_LOW(MIN_LOW)) qual_i (
    .clk         (clk),
    .sync_low_i  (sync_low),
    .low_cnt_o   (low_cnt),
    .qualified_o (qualified)
  );

  cpu_rstseq_ctrl #(.NUM_IRQ(NUM_IRQ), .NMI_IDX(NMI_IDX)) ctrl_i (
    .clk          (clk),
    .active_i     (qualified),
    .periph_rst_o (periph_rst_o),
    .core_pulse_o (core_rst_pulse_o),
    .pc_clr_o     (pc_clr_o),
    .ir_clr_o     (ir_clr_o),
    .irq_en_clr_o (irq_en_clr_o),
    .sod_dis_o    (sod_dis_o),
    .bus_float_o  (bus_float_o)
  );

endmodule

// File: rtl/cpu_reset_seq_chk.sv
module cpu_reset_seq_chk #(
  parameter int unsigned MIN_LOW = 3,
  parameter int unsigned NUM_IRQ = 5,
  parameter int unsigned NMI_IDX = 0,
  parameter int unsigned CW      = 2
) (
  input logic               clk,
  input logic               sync_low,
  input logic [CW-1:0]      low_cnt,
  input logic               periph_rst_o,
  input logic               core_rst_pulse_o,
  input logic               pc_clr_o,
  input logic               ir_clr_o,
  input logic [NUM_IRQ-1:0] irq_en_clr_o,
  input logic               sod_dis_o,
  input logic               bus_float_o
);

  // Checks start once the first reset has been accepted and state is defined.
  logic armed;
  always_ff @(posedge clk) armed <= armed | periph_rst_o;

  AST_QUAL_NEEDS_RUN: assert property (@(posedge clk) disable iff (!armed)
    $rose(periph_rst_o) |-> (low_cnt == CW'(MIN_LOW))); // R2
  AST_HOLD_WHILE_LOW: assert property (@(posedge clk) disable iff (!armed)
    (periph_rst_o && sync_low) |=> periph_rst_o); // R4
  AST_RELEASE_ON_HIGH: assert property (@(posedge clk) disable iff (!armed)
    (periph_rst_o && !sync_low) |=> !periph_rst_o); // R4
  AST_CLEAR_STROBES: assert property (@(posedge clk) disable iff (!armed)
    periph_rst_o |-> (pc_clr_o && ir_clr_o)); // R5
  AST_PULSE_AT_ENTRY: assert property (@(posedge clk) disable iff (!armed)
    $rose(periph_rst_o) |-> core_rst_pulse_o); // R6
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!armed)
    core_rst_pulse_o |=> !core_rst_pulse_o); // R6
  AST_MASKABLE_ONLY: assert property (@(posedge clk) disable iff (!armed)
    periph_rst_o |-> ($countones(irq_en_clr_o) == NUM_IRQ - 1 && !irq_en_clr_o[NMI_IDX])); // R7
  AST_NO_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!armed)
    !periph_rst_o |-> (irq_en_clr_o == '0)); // R7
  AST_BUS_FLOAT: assert property (@(posedge clk) disable iff (!armed)
    periph_rst_o |-> (bus_float_o && sod_dis_o)); // R8
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!armed)
    !sync_low |=> (low_cnt == '0)); // R9
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!armed)
    low_cnt <= CW'(MIN_LOW)); // R10

endmodule

bind cpu_reset_seq cpu_reset_seq_chk #(
  .MIN_LOW (MIN_LOW),
  .NUM_IRQ (NUM_IRQ),
  .NMI_IDX (NMI_IDX),
  .CW      (CW)
) chk_i (
  .clk              (clk),
  .sync_low         (sync_low),
  .low_cnt          (low_cnt),
  .periph_rst_o     (periph_rst_o),
  .core_rst_pulse_o (core_rst_pulse_o),
  .pc_clr_o         (pc_clr_o),
  .ir_clr_o         (ir_clr_o),
  .irq_en_clr_o     (irq_en_clr_o),
  .sod_dis_o        (sod_dis_o),
  .bus_float_o      (bus_float_o)
);

// File: tb/cpu_reset_seq_tb_top.sv
module cpu_reset_seq_tb_top;

  localparam int NUM_IRQ = 5;

  logic               clk = 1'b0;
  logic               rst_pin_n = 1'b0;
  logic               periph_rst_o;
  logic               core_rst_pulse_o;
  logic               pc_clr_o;
  logic               ir_clr_o;
  logic [NUM_IRQ-1:0] irq_en_clr_o;
  logic               sod_dis_o;
  logic               bus_float_o;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #2 clk = ~clk;

  cpu_reset_seq dut_i (
    .clk              (clk),
    .rst_pin_n        (rst_pin_n),
    .periph_rst_o     (periph_rst_o),
    .core_rst_pulse_o (core_rst_pulse_o),
    .pc_clr_o         (pc_clr_o),
    .ir_clr_o         (ir_clr_o),
    .irq_en_clr_o     (irq_en_clr_o),
    .sod_dis_o        (sod_dis_o),
    .bus_float_o      (bus_float_o)
  );

  // Vector: {pin driven before the edge, expected periph reset after it, expected core pulse}.
  // The expected reset after edge n is high when the pin was low at edges n-2, n-3 and n-4.
  localparam int NVEC = 24;
  localparam logic [2:0] VEC [NVEC] = '{
    3'b100, 3'b000, 3'b000, 3'b100, 3'b100, 3'b100, 3'b100, 3'b000,
    3'b100, 3'b000, 3'b000, 3'b100, 3'b100, 3'b100, 3'b000, 3'b000,
    3'b000, 3'b000, 3'b011, 3'b110, 3'b110, 3'b100, 3'b100, 3'b100
  };

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge: set the pin, pass one rising edge, return at the next falling edge.
  task automatic drive(input logic v);
    rst_pin_n = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  // Check every reset output against the expected reset level.
  task automatic check_all(input string req, input logic exp_rst, input logic exp_pulse);
    check(req, "periph_rst_o", 32'(periph_rst_o), 32'(exp_rst));
    check(req, "core_rst_pulse_o", 32'(core_rst_pulse_o), 32'(exp_pulse));
    check("R5", "pc_clr_o", 32'(pc_clr_o), 32'(exp_rst));
    check("R5", "ir_clr_o", 32'(ir_clr_o), 32'(exp_rst));
    check("R7", "irq_en_clr_o", 32'(irq_en_clr_o), exp_rst ? 32'h1E : 32'h0);
    check("R8", "sod_dis_o", 32'(sod_dis_o), 32'(exp_rst));
    check("R8", "bus_float_o", 32'(bus_float_o), 32'(exp_rst));
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int pulses;
    @(negedge clk);
    // Power-up reset: long low, then release.
    for (int i = 0; i < 8; i++) drive(1'b0);
    check_all("R4", 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) drive(1'b1);
    check_all("R1", 1'b0, 1'b0);

    // Table walk: short pulses (R3), split pulses (R9), accepted reset and release (R2, R4, R6).
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][2]);
      check_all((i < 14) ? "R3_R9" : "R2_R4", VEC[i][1], VEC[i][0]);
    end

    // R1: pin steady high never produces a reset.
    for (int i = 0; i < 20; i++) begin
      drive(1'b1);
      check_all("R1", 1'b0, 1'b0);
    end

    // R2 boundary: exactly MIN_LOW low samples give a one-cycle reset four edges later.
    for (int j = 0; j < 8; j++) begin
      drive((j < 3) ? 1'b0 : 1'b1);
      check_all("R2", (j == 4), (j == 4));
    end

    // R10: long hold keeps the reset and gives a single pulse; R4 release timing.
    pulses = 0;
    for (int j = 0; j < 60; j++) begin
      drive(1'b0);
      if (core_rst_pulse_o) pulses++;
      if (j >= 4) check("R10", "periph_rst_o held", 32'(periph_rst_o), 32'd1);
    end
    check("R10", "pulse count", 32'(pulses), 32'd1);
    drive(1'b1);
    check_all("R4", 1'b1, 1'b0);
    drive(1'b1);
    check_all("R4", 1'b1, 1'b0);
    drive(1'b1);
    check_all("R4", 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) drive(1'b1);
    check_all("R1", 1'b0, 1'b0);

    finish_run();
  end

endmodule